// File: doc/BRIEF.md
# Coprocessor Lock and Start Semaphore

This block holds two control registers that a main sequencer and two coprocessors share. The first is a lock register. Each bit guards one region of a scratch window, which sits at addresses 0x200 to 0x2ff. A requester asks for a lock by writing 1 to its bit, then polls the register until its own view of that bit reads 1. It gives the lock back by writing 0. A request made while another requester holds the lock stays pending inside the block. The requester gets the lock on its own once the lock is free again.

The second register is a thread-sync word. Its low three bits form a start-up semaphore. The main sequencer loads the whole word, typically 0x7, before it starts the coprocessors. As each coprocessor comes up, it clears its own semaphore bit with a clear-mask write. Clears made in the same cycle are merged bit by bit, so no clear is lost. The upper bits of the word are not touched by a clear.

Each requester has its own write port with an enable, a register select and data. Reads go through one shared path. The reader gives a requester id and a register select. A lock read returns that requester's own view of the locks.

Top module: `colk_top`

## Requirements
- R1: After reset every lock is free, no request is pending, and the thread-sync register reads 0 through every requester's view.
- R2: A write with select 0 (lock register) and data bit i = 1 to a free lock i grants the lock at that clock edge. From the next cycle, a lock read by that requester returns bit i = 1, and lock reads by the other requesters return bit i = 0.
- R3: When several requesters write 1 to the same free lock in the same cycle, the lowest requester index wins. Index 0 is the main sequencer, then coprocessor 1, then coprocessor 2.
- R4: A request to a held lock stays pending, and the requester reads 0 for that bit. At the edge after the holder's release, the pending requester with the highest priority is granted the lock.
- R5: A lock write by the holder with data bit i = 0 frees lock i at that edge.
- R6: A lock write with bit i = 0 from a requester that does not hold lock i leaves the holder and its read value unchanged.
- R7: A thread-sync write (select 1) from the main sequencer (index 0) loads the full data word.
- R8: A thread-sync write from a coprocessor clears the register bits where data bits [2:0] are 1. Bits [31:3] of the register are left unchanged, whatever the data holds there.
- R9: Clears from both coprocessors in the same cycle both take effect. A clear in the same cycle as a main-sequencer load is applied after the load.
- R10: The lock bits are independent. Different requesters can hold different locks at the same time.
- R11: Lock-read bits at and above the lock count read 0. A lock read with a requester id of 3 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 3 | Write enable, one per requester (bit 0 = main sequencer) |
| wrSel | input | 3 | Register select per requester: 0 lock, 1 thread-sync |
| wrData | input | 96 | Write data, 32 bits per requester, requester r at [32r+31:32r] |
| rdId | input | 2 | Requester whose lock view is read |
| rdSel | input | 1 | Read select: 0 lock, 1 thread-sync |
| rdData | output | 32 | Read data |

## Verification
The assertions check three things on every cycle. Main-sequencer priority on a free lock. That a held lock keeps its owner while the owner does not write the lock register, and is freed when the owner writes 0. And that the thread-sync word is loaded correctly, that requested semaphore bits are cleared, and that its upper bits do not change under clears. Other behaviours span several cycles or several requesters, and only the bench scenarios show them. These are the hand-over of a released lock to a pending requester in priority order, a non-owner release being ignored, merged clears in one cycle, and the per-requester read view.

// File: rtl/colk_pkg.sv
package colk_pkg;
  parameter int unsigned SEM_W = 3;

  typedef enum logic {
    SEL_LOCK = 1'b0,
    SEL_SYNC = 1'b1
  } regSel_e;

  typedef struct packed {
    logic             loadEn;
    logic [SEM_W-1:0] clrMask;
  } syncStrb_t;
endpackage

// File: rtl/colk_lock_ctrl.sv
module colk_lock_ctrl
  import colk_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 3,
  parameter int unsigned NUM_LOCKS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ID_W      = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        wrEn,
  input  logic [NUM_REQ-1:0]        wrSel,
  input  logic [NUM_REQ*DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]           rdId,
  output logic [NUM_LOCKS-1:0]      lockView,
  output syncStrb_t                 strb
);
  logic [NUM_REQ-1:0]   lockWr;
  logic [NUM_LOCKS-1:0] held, heldNxt;
  logic [ID_W-1:0]      owner    [NUM_LOCKS];
  logic [ID_W-1:0]      ownerNxt [NUM_LOCKS];
  logic [NUM_LOCKS-1:0] pend     [NUM_REQ];
  logic [NUM_LOCKS-1:0] pendNxt  [NUM_REQ];
  logic [NUM_LOCKS-1:0] reqNow   [NUM_REQ];

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++)
      lockWr[r] = wrEn[r] && (wrSel[r] == SEL_LOCK);
  end

  always_comb begin
    logic            anyReq;
    logic [ID_W-1:0] win;
    anyReq  = 1'b0;
    win     = '0;
    heldNxt = held;
    for (int r = 0; r < NUM_REQ; r++) begin
      reqNow[r]  = lockWr[r] ? wrData[r*DATA_W +: NUM_LOCKS] : pend[r];
      pendNxt[r] = reqNow[r];
    end
    for (int i = 0; i < NUM_LOCKS; i++) begin
      ownerNxt[i] = owner[i];
      if (held[i]) begin
        for (int r = 0; r < NUM_REQ; r++) begin
          if (owner[i] == ID_W'(r)) begin
            if (lockWr[r] && !reqNow[r][i]) heldNxt[i] = 1'b0;
            pendNxt[r][i] = 1'b0;
          end
        end
      end else begin
        anyReq = 1'b0;
        win    = '0;
        for (int r = NUM_REQ - 1; r >= 0; r--) begin
          if (reqNow[r][i]) begin
            anyReq = 1'b1;
            win    = ID_W'(r);
          end
        end
        if (anyReq) begin
          heldNxt[i]  = 1'b1;
          ownerNxt[i] = win;
          for (int r = 0; r < NUM_REQ; r++)
            if (win == ID_W'(r)) pendNxt[r][i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      for (int i = 0; i < NUM_LOCKS; i++) owner[i] <= '0;
      for (int r = 0; r < NUM_REQ; r++) pend[r] <= '0;
    end else begin
      held <= heldNxt;
      for (int i = 0; i < NUM_LOCKS; i++) owner[i] <= ownerNxt[i];
      for (int r = 0; r < NUM_REQ; r++) pend[r] <= pendNxt[r];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LOCKS; i++)
      lockView[i] = held[i] && (owner[i] == rdId);
  end

  always_comb begin
    strb.loadEn  = wrEn[0] && (wrSel[0] == SEL_SYNC);
    strb.clrMask = '0;
    for (int r = 1; r < NUM_REQ; r++)
      if (wrEn[r] && (wrSel[r] == SEL_SYNC))
        strb.clrMask = strb.clrMask | wrData[r*DATA_W +: SEM_W];
  end

  for (genvar gi = 0; gi < NUM_LOCKS; gi++) begin : g_lockChk
    // R3
    main_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!held[gi] && lockWr[0] && wrData[gi]) |=> (held[gi] && owner[gi] == '0));
    // R6
    holder_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[gi] && !lockWr[owner[gi]]) |=> (held[gi] && $stable(owner[gi])));
    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[gi] && lockWr[owner[gi]] && !wrData[int'(owner[gi])*DATA_W + gi])
        |=> !held[gi]);
  end
endmodule

// File: rtl/colk_sync_dp.sv
module colk_sync_dp
  import colk_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  syncStrb_t            strb,
  input  logic [DATA_W-1:0]    loadData,
  input  logic [NUM_LOCKS-1:0] lockView,
  input  logic                 rdSel,
  output logic [DATA_W-1:0]    rdData
);
  localparam int unsigned PAD_W = DATA_W - NUM_LOCKS;

  logic [DATA_W-1:0] syncReg, syncNxt;

  always_comb begin
    syncNxt = strb.loadEn ? loadData : syncReg;
    syncNxt[SEM_W-1:0] = syncNxt[SEM_W-1:0] & ~strb.clrMask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) syncReg <= '0;
    else        syncReg <= syncNxt;
  end

  always_comb begin
    if (rdSel == SEL_SYNC) rdData = syncReg;
    else                   rdData = {{PAD_W{1'b0}}, lockView};
  end

  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadEn && strb.clrMask == '0) |=> (syncReg == $past(loadData)));
  // R8
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadEn |=> $stable(syncReg[DATA_W-1:SEM_W]));

  for (genvar gb = 0; gb < SEM_W; gb++) begin : g_semChk
    // R9
    sem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clrMask[gb] |=> !syncReg[gb]);
  end
endmodule

// File: rtl/colk_top.sv
module colk_top
  import colk_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 3,
  parameter int unsigned NUM_LOCKS = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ID_W      = $clog2(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        wrEn,
  input  logic [NUM_REQ-1:0]        wrSel,
  input  logic [NUM_REQ*DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]           rdId,
  input  logic                      rdSel,
  output logic [DATA_W-1:0]         rdData
);
  syncStrb_t            strb;
  logic [NUM_LOCKS-1:0] lockView;

  colk_lock_ctrl #(
    .NUM_REQ(NUM_REQ), .NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdId(rdId), .lockView(lockView), .strb(strb)
  );

  colk_sync_dp #(
    .NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadData(wrData[DATA_W-1:0]),
    .lockView(lockView), .rdSel(rdSel), .rdData(rdData)
  );
endmodule

// File: tb/colk_top_tb.sv
module colk_top_tb;
  localparam int CLK_P   = 10;
  localparam int NUM_REQ = 3;
  localparam int DATA_W  = 32;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [NUM_REQ-1:0]        wrEn;
  logic [NUM_REQ-1:0]        wrSel;
  logic [NUM_REQ*DATA_W-1:0] wrData;
  logic [1:0]                rdId;
  logic                      rdSel;
  logic [DATA_W-1:0]         rdData;

  int total = 0;
  int bad   = 0;

  colk_top u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdId(rdId), .rdSel(rdSel), .rdData(rdData)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic setWr(int r, logic sel, logic [31:0] d);
    wrEn[r]  = 1'b1;
    wrSel[r] = sel;
    wrData[r*DATA_W +: DATA_W] = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wrEn = '0;
  endtask

  task automatic peek(int id, logic sel, output logic [31:0] v);
    rdId  = 2'(id);
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 4; r++) begin
      peek(r, 1'b0, v); check("R1 lock view", v, 32'h0);
    end
    peek(0, 1'b1, v); check("R1 sync", v, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    setWr(1, 1'b0, 32'h01); tick();
    peek(1, 1'b0, v); check("R2 owner view", v, 32'h01);
    peek(0, 1'b0, v); check("R2 other view", v, 32'h00);
    setWr(1, 1'b0, 32'h00); tick();
    peek(1, 1'b0, v); check("R5 released", v, 32'h00);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    setWr(0, 1'b0, 32'h04); setWr(1, 1'b0, 32'h04); setWr(2, 1'b0, 32'h04);
    tick();
    peek(0, 1'b0, v); check("R3 main wins", v, 32'h04);
    peek(1, 1'b0, v); check("R3 cp1 loses", v, 32'h00);
    peek(2, 1'b0, v); check("R3 cp2 loses", v, 32'h00);
    setWr(0, 1'b0, 32'h00); tick();
    peek(1, 1'b0, v); check("R4 not yet", v, 32'h00);
    tick();
    peek(1, 1'b0, v); check("R4 cp1 handover", v, 32'h04);
    peek(2, 1'b0, v); check("R4 cp2 waits", v, 32'h00);
    setWr(1, 1'b0, 32'h00); tick(); tick();
    peek(2, 1'b0, v); check("R4 cp2 handover", v, 32'h04);
    setWr(2, 1'b0, 32'h00); tick();
    peek(2, 1'b0, v); check("R5 cp2 released", v, 32'h00);
  endtask

  task automatic t_nonowner();
    logic [31:0] v;
    setWr(0, 1'b0, 32'h08); tick();
    setWr(2, 1'b0, 32'h00); tick();
    peek(0, 1'b0, v); check("R6 holder kept", v, 32'h08);
    setWr(2, 1'b0, 32'h10); tick();
    peek(0, 1'b0, v); check("R10 main lock3", v, 32'h08);
    peek(2, 1'b0, v); check("R10 cp2 lock4", v, 32'h10);
    peek(3, 1'b0, v); check("R11 bad id", v, 32'h00);
    setWr(0, 1'b0, 32'h00); setWr(2, 1'b0, 32'h00); tick();
    peek(0, 1'b0, v); check("R5 main free", v, 32'h00);
    peek(2, 1'b0, v); check("R5 cp2 free", v, 32'h00);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    setWr(0, 1'b1, 32'hA5A5_0007); tick();
    peek(0, 1'b1, v); check("R7 load", v, 32'hA5A5_0007);
    setWr(1, 1'b1, 32'h0000_0002); tick();
    peek(1, 1'b1, v); check("R8 cp1 clear", v, 32'hA5A5_0005);
    setWr(2, 1'b1, 32'hFFFF_0004); tick();
    peek(2, 1'b1, v); check("R8 upper kept", v, 32'hA5A5_0001);
  endtask

  task automatic t_concurrent();
    logic [31:0] v;
    setWr(0, 1'b1, 32'h0000_0007); tick();
    setWr(1, 1'b1, 32'h2); setWr(2, 1'b1, 32'h4); tick();
    peek(0, 1'b1, v); check("R9 both clears", v, 32'h0000_0001);
    setWr(0, 1'b1, 32'h0000_0007); setWr(1, 1'b1, 32'h2); tick();
    peek(0, 1'b1, v); check("R9 clear after load", v, 32'h0000_0005);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wrEn = '0; wrSel = '0; wrData = '0; rdId = '0; rdSel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_prio();
    t_nonowner();
    t_sync();
    t_concurrent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule